// File: doc/BRIEF.md
# Stereo PDM Decimator with Gain

This block receives one 1-bit pulse-density data line shared by two microphones and produces a 16-bit PCM sample stream for each of them. It generates the microphone clock by dividing the system clock. The two microphones take turns driving the line. The left bit is captured on the rising edge of the generated clock and the right bit on the falling edge.

Each bitstream first maps every bit to +1 or -1. It then passes through a fourth-order cascaded integrator-comb filter that decimates by 64. The filter result is scaled to 16 signed bits and multiplied by a 14-bit unsigned gain with 10 fractional bits, then clipped to the signed 16-bit range. Each channel has its own active-low soft reset, sample enable and gain. Each new sample is announced by a single-cycle strobe.

The filter output is not trustworthy until its window has filled. For this reason each channel drops its first four filter outputs after it starts before it raises its strobe. A 2-bit rate code picks one of three clock dividers:

| Rate code | Output rate | Clock divider |
|---|---|---|
| 1 | 16 kHz | `HALF_R1` |
| 0 | 15.625 kHz | `HALF_R0` |
| 3 | 8 kHz | `HALF_R3` |

Code 2 behaves like code 1. Each divider value must be at least 2.

Top module: `pdm_stereo_decim`

## Requirements
- R1: The left channel takes the data bit that is present when `pdm_clk` rises. The right channel takes the bit that is present when `pdm_clk` falls. In steady state, a line that is high while the clock is low and low while the clock is high gives left = 32767 and right = -32768 at unity gain.
- R2: While a channel runs, it emits exactly one single-cycle strobe for every 64 captured bits. Its PCM output changes only together with a strobe or because of a soft reset.
- R3: The period of `pdm_clk` is 2*HALF_R0 system cycles for rate code 0, 2*HALF_R1 for codes 1 and 2, and 2*HALF_R3 for code 3.
- R4: At unity gain, the settled output for a constant-1 bitstream is 32767. For a constant-0 bitstream it is -32768. For a bitstream that alternates on every capture it is exactly 0.
- R5: The output equals floor(filter_sample * gain / 1024), where gain is read as an unsigned 14-bit value and 0x400 is unity.
- R6: A gain product outside the signed 16-bit range is clipped to 32767 or -32768.
- R7: While a channel's soft reset is low, its strobe stays low and its PCM output reads 0. On release, its filter state starts from zero.
- R8: While a channel's enable is low, it captures nothing, raises no strobe and holds its last PCM value.
- R9: After a channel starts with a fresh filter, its first strobe comes after exactly 320 captured bits. The first four filter outputs are dropped.
- R10: `pdm_clk` stays low unless `clk_en` is high and at least one channel has soft reset high and enable high.
- R11: After the system reset, `pdm_clk`, both strobes and both PCM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Allows the microphone clock to run |
| rate_sel | input | 2 | Output rate code |
| pdm_din | input | 1 | Shared pulse-density data line |
| pdm_clk | output | 1 | Generated microphone clock |
| l_srst_n | input | 1 | Left channel soft reset, active low |
| l_en | input | 1 | Left channel sample enable |
| l_gain | input | 14 | Left gain, unsigned, 10 fractional bits |
| r_srst_n | input | 1 | Right channel soft reset, active low |
| r_en | input | 1 | Right channel sample enable |
| r_gain | input | 14 | Right gain, unsigned, 10 fractional bits |
| l_pcm | output | 16 | Left PCM sample, signed |
| l_valid | output | 1 | Left sample strobe |
| r_pcm | output | 16 | Right PCM sample, signed |
| r_valid | output | 1 | Right sample strobe |

## Verification
The bench builds the block with clock dividers of 3, 2 and 4 for rate codes 0, 1 and 3, in place of the default dividers of several tens of cycles. This makes one PCM sample take about 256 system cycles. As a result, the 320-bit start-up drop, many gain and pattern combinations, and a separate period measurement for every rate code all fit into a short run. Filter order, decimation ratio and drop count stay at their defaults, so the expected sample values and start-up timing are the real ones.

// File: rtl/pdm_pkg.sv
// Shared widths and codes for the stereo PDM decimator.
// Assumes: PCM width 16, gain with 10 fractional bits.
package pdm_pkg;
    localparam int PCM_W     = 16;
    localparam int GAIN_W    = 14;
    localparam int GAIN_FRAC = 10;
    localparam int NUM_CH    = 2;   // index 0 = left, 1 = right

    typedef enum logic [1:0] {
        RATE_15K6 = 2'd0,
        RATE_16K  = 2'd1,
        RATE_ALT  = 2'd2,
        RATE_8K   = 2'd3
    } rate_e;
endpackage

// File: rtl/pdm_clkgen.sv
// Divides the system clock into the microphone clock and captures the
// shared data line on each of its edges.
// Assumes: every half period is at least 2 system cycles, so the
// strobes of two consecutive edges never touch.
module pdm_clkgen #(
    parameter int HALF_R0 = 32,
    parameter int HALF_R1 = 31,
    parameter int HALF_R3 = 63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    input  logic       din,
    output logic       pclk,
    output logic       rise_stb,
    output logic       rise_bit,
    output logic       fall_stb,
    output logic       fall_bit
);
    import pdm_pkg::*;

    localparam int HMAX = (HALF_R0 > HALF_R1) ? ((HALF_R0 > HALF_R3) ? HALF_R0 : HALF_R3)
                                              : ((HALF_R1 > HALF_R3) ? HALF_R1 : HALF_R3);
    localparam int CW   = $clog2(HMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    // Select the terminal count of the half-period counter.
    always_comb begin
        case (rate_e'(rate_sel))
            RATE_15K6: half_m1 = CW'(HALF_R0 - 1);
            RATE_8K:   half_m1 = CW'(HALF_R3 - 1);
            default:   half_m1 = CW'(HALF_R1 - 1);
        endcase
    end

    // Toggle the clock each half period and latch the bit at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            pclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            rise_bit <= 1'b0;
            fall_bit <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            if (cnt >= half_m1) begin
                cnt  <= '0;
                pclk <= ~pclk;
                if (!pclk) begin
                    rise_stb <= 1'b1;
                    rise_bit <= din;
                end else begin
                    fall_stb <= 1'b1;
                    fall_bit <= din;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdm_cic.sv
// Cascaded integrator-comb decimator for a 1-bit stream mapped to +/-1.
// Output is scaled to PCM_W signed bits and clipped at the top of range.
// Assumes: in_stb pulses are at least 3 cycles apart.
module pdm_cic #(
    parameter int ORDER    = 4,
    parameter int DEC_LOG2 = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_stb,
    input  logic                              in_bit,
    output logic                              out_stb,
    output logic signed [pdm_pkg::PCM_W-1:0]  out_data
);
    import pdm_pkg::*;

    localparam int W     = ORDER * DEC_LOG2 + 2;
    localparam int SHIFT = ORDER * DEC_LOG2 - (PCM_W - 1);
    localparam logic signed [W-1:0] MAXV = W'((1 << (PCM_W - 1)) - 1);
    localparam logic signed [W-1:0] MINV = -MAXV - W'(1);

    logic signed [W-1:0] integ [ORDER];
    logic signed [W-1:0] dly   [ORDER];
    logic signed [W-1:0] comb_v [ORDER+1];
    logic signed [W-1:0] step;
    logic signed [W-1:0] scaled;
    logic [DEC_LOG2-1:0] dec_cnt;
    logic                dump;

    assign step = in_bit ? W'(1) : {W{1'b1}};

    // Comb chain evaluated from the last integrator and stored delays.
    always_comb begin
        comb_v[0] = integ[ORDER-1];
        for (int k = 0; k < ORDER; k++) begin
            comb_v[k+1] = comb_v[k] - dly[k];
        end
        scaled = comb_v[ORDER] >>> SHIFT;
    end

    // Integrate each input bit and flag every 2**DEC_LOG2-th one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= '0;
            dec_cnt <= '0;
            dump    <= 1'b0;
        end else begin
            dump <= 1'b0;
            if (in_stb) begin
                integ[0] <= integ[0] + step;
                for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
                dec_cnt <= dec_cnt + 1'b1;
                if (dec_cnt == '1) dump <= 1'b1;
            end
        end
    end

    // Run the combs at the decimated rate and clip the scaled result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= dump;
            if (dump) begin
                for (int k = 0; k < ORDER; k++) dly[k] <= comb_v[k];
                if (scaled > MAXV)      out_data <= MAXV[PCM_W-1:0];
                else if (scaled < MINV) out_data <= MINV[PCM_W-1:0];
                else                    out_data <= scaled[PCM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pdm_gain.sv
// Multiplies a PCM sample by an unsigned fixed-point gain, floors the
// fraction away and clips to the signed PCM range. One cycle latency.
// Drops the first SKIP_OUT samples after each start.
module pdm_gain #(
    parameter int SKIP_OUT = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    input  logic                                in_stb,
    input  logic signed [pdm_pkg::PCM_W-1:0]    in_data,
    input  logic [pdm_pkg::GAIN_W-1:0]          gain,
    output logic signed [pdm_pkg::PCM_W-1:0]    pcm,
    output logic                                valid
);
    import pdm_pkg::*;

    localparam int PW = PCM_W + GAIN_W + 1;
    localparam int SW = $clog2(SKIP_OUT + 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (PCM_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic [SW-1:0]        skip_cnt;

    // Signed product and arithmetic shift by the fraction width.
    always_comb begin
        prod    = PW'(in_data) * PW'($signed({1'b0, gain}));
        shifted = prod >>> GAIN_FRAC;
    end

    // Drop start-up samples, then publish clipped samples with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_cnt <= '0;
            pcm      <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en) begin
                skip_cnt <= '0;
            end else if (in_stb) begin
                if (skip_cnt != SW'(SKIP_OUT)) begin
                    skip_cnt <= skip_cnt + 1'b1;
                end else begin
                    valid <= 1'b1;
                    if (shifted > MAXV)      pcm <= MAXV[PCM_W-1:0];
                    else if (shifted < MINV) pcm <= MINV[PCM_W-1:0];
                    else                     pcm <= shifted[PCM_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/pdm_chan.sv
// One audio channel: decimation filter followed by the gain stage.
// The channel soft reset clears all of its state.
module pdm_chan #(
    parameter int ORDER    = 4,
    parameter int DEC_LOG2 = 6,
    parameter int SKIP_OUT = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              srst_n,
    input  logic                              en,
    input  logic                              bit_stb,
    input  logic                              bit_val,
    input  logic [pdm_pkg::GAIN_W-1:0]        gain,
    output logic signed [pdm_pkg::PCM_W-1:0]  pcm,
    output logic                              valid
);
    import pdm_pkg::*;

    logic                    ch_rst_n;
    logic                    cic_stb;
    logic signed [PCM_W-1:0] cic_data;

    assign ch_rst_n = rst_n & srst_n;

    pdm_cic #(.ORDER(ORDER), .DEC_LOG2(DEC_LOG2)) u_cic (
        .clk      (clk),
        .rst_n    (ch_rst_n),
        .in_stb   (bit_stb & en),
        .in_bit   (bit_val),
        .out_stb  (cic_stb),
        .out_data (cic_data)
    );

    pdm_gain #(.SKIP_OUT(SKIP_OUT)) u_gain (
        .clk     (clk),
        .rst_n   (ch_rst_n),
        .en      (en),
        .in_stb  (cic_stb),
        .in_data (cic_data),
        .gain    (gain),
        .pcm     (pcm),
        .valid   (valid)
    );
endmodule

// File: rtl/pdm_stereo_decim.sv
// Top level: one clock generator feeding two channel pipelines.
// The defaults suit a 64 MHz system clock, rounded to whole cycles.
module pdm_stereo_decim #(
    parameter int HALF_R0  = 32,
    parameter int HALF_R1  = 31,
    parameter int HALF_R3  = 63,
    parameter int ORDER    = 4,
    parameter int DEC_LOG2 = 6,
    parameter int SKIP_OUT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_en,
    input  logic [1:0]  rate_sel,
    input  logic        pdm_din,
    output logic        pdm_clk,
    input  logic        l_srst_n,
    input  logic        l_en,
    input  logic [13:0] l_gain,
    input  logic        r_srst_n,
    input  logic        r_en,
    input  logic [13:0] r_gain,
    output logic [15:0] l_pcm,
    output logic        l_valid,
    output logic [15:0] r_pcm,
    output logic        r_valid
);
    import pdm_pkg::*;

    logic [NUM_CH-1:0]              srst_v, en_v, stb_v, bit_v, valid_v;
    logic [NUM_CH-1:0][GAIN_W-1:0]  gain_v;
    logic [NUM_CH-1:0][PCM_W-1:0]   pcm_v;
    logic                           run;
    logic                           rise_stb, rise_bit, fall_stb, fall_bit;

    assign srst_v = {r_srst_n, l_srst_n};
    assign en_v   = {r_en, l_en};
    assign gain_v = {r_gain, l_gain};
    assign stb_v  = {fall_stb, rise_stb};
    assign bit_v  = {fall_bit, rise_bit};
    assign run    = clk_en & |(srst_v & en_v);

    pdm_clkgen #(.HALF_R0(HALF_R0), .HALF_R1(HALF_R1), .HALF_R3(HALF_R3)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate_sel (rate_sel),
        .din      (pdm_din),
        .pclk     (pdm_clk),
        .rise_stb (rise_stb),
        .rise_bit (rise_bit),
        .fall_stb (fall_stb),
        .fall_bit (fall_bit)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic signed [PCM_W-1:0] ch_pcm;
        pdm_chan #(.ORDER(ORDER), .DEC_LOG2(DEC_LOG2), .SKIP_OUT(SKIP_OUT)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst_n  (srst_v[ch]),
            .en      (en_v[ch]),
            .bit_stb (stb_v[ch]),
            .bit_val (bit_v[ch]),
            .gain    (gain_v[ch]),
            .pcm     (ch_pcm),
            .valid   (valid_v[ch])
        );
        assign pcm_v[ch] = ch_pcm;
    end

    assign l_pcm   = pcm_v[0];
    assign r_pcm   = pcm_v[1];
    assign l_valid = valid_v[0];
    assign r_valid = valid_v[1];
endmodule

// File: rtl/pdm_stereo_decim_chk.sv
// Port-level properties of the stereo PDM decimator, bound to the top.
module pdm_stereo_decim_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_en,
    input logic [1:0]  rate_sel,
    input logic        pdm_din,
    input logic        pdm_clk,
    input logic        l_srst_n,
    input logic        l_en,
    input logic [13:0] l_gain,
    input logic        r_srst_n,
    input logic        r_en,
    input logic [13:0] r_gain,
    input logic [15:0] l_pcm,
    input logic        l_valid,
    input logic [15:0] r_pcm,
    input logic        r_valid
);
    AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && ((l_srst_n && l_en) || (r_srst_n && r_en))) |=> !pdm_clk); // R10
    AST_L_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        l_valid |=> !l_valid); // R2
    AST_R_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |=> !r_valid); // R2
    AST_L_PCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l_pcm) |-> (l_valid || $past(!l_srst_n))); // R2
    AST_R_PCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_pcm) |-> (r_valid || $past(!r_srst_n))); // R2
    AST_L_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !l_srst_n |=> (!l_valid && l_pcm == 16'd0)); // R7
    AST_R_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !r_srst_n |=> (!r_valid && r_pcm == 16'd0)); // R7
    AST_L_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |=> !l_valid); // R8
    AST_R_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en |=> !r_valid); // R8
endmodule

bind pdm_stereo_decim pdm_stereo_decim_chk u_chk (.*);

// File: tb/tb_pdm_stereo_decim.sv
`timescale 1ns/1ps
module tb_pdm_stereo_decim;
    localparam int H0 = 3, H1 = 2, H3 = 4;
    localparam int NV = 10;
    // pattern codes: 0 all zero, 1 all one, 2 high while clock low, 3 high while clock high, 4 alternate
    localparam int V_MODE [NV] = '{1, 0, 2, 3, 2, 4, 1, 0, 3, 2};
    localparam int V_LG   [NV] = '{'h400, 'h400, 'h400, 'h200, 'h800, 'h400, 'h000, 'h3FFF, 'h600, 'h3FF};
    localparam int V_RG   [NV] = '{'h400, 'h400, 'h400, 'h800, 'h800, 'h3FFF, 'h001, 'h001, 'h002, 'h3FF};
    localparam int V_LE   [NV] = '{32767, -32768, 32767, -16384, 32767, 0, 0, -32768, -32768, 32735};
    localparam int V_RE   [NV] = '{32767, -32768, -32768, 32767, -32768, 0, 31, -32, 63, -32736};
    localparam string V_TAG [NV] = '{"R4", "R4", "R1", "R5 R6", "R6", "R4", "R5", "R6", "R1 R6", "R5"};

    logic clk = 0, rst_n = 0, clk_en = 1, pdm_din = 0;
    logic [1:0] rate_sel = 2'd1;
    logic l_srst_n = 1, l_en = 0, r_srst_n = 1, r_en = 0;
    logic [13:0] l_gain = 14'h400, r_gain = 14'h400;
    logic pdm_clk, l_valid, r_valid;
    logic [15:0] l_pcm, r_pcm;

    int total = 0, bad = 0;
    int mode = 1;
    int cyc = 0, rise_cnt = 0, last_rise = 0, prev_rise = 0;
    int lv_cnt = 0, rv_cnt = 0, rise_at_lv = 0, rise_at_lv_prev = 0;
    logic prev_pc = 0, tgl = 0;

    always #4 clk = ~clk;

    pdm_stereo_decim #(.HALF_R0(H0), .HALF_R1(H1), .HALF_R3(H3)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rate_sel(rate_sel),
        .pdm_din(pdm_din), .pdm_clk(pdm_clk),
        .l_srst_n(l_srst_n), .l_en(l_en), .l_gain(l_gain),
        .r_srst_n(r_srst_n), .r_en(r_en), .r_gain(r_gain),
        .l_pcm(l_pcm), .l_valid(l_valid), .r_pcm(r_pcm), .r_valid(r_valid));

    // Observe edges and strobes, and drive the data line between edges.
    always @(negedge clk) begin
        cyc++;
        if (pdm_clk && !prev_pc) begin
            rise_cnt++;
            prev_rise = last_rise;
            last_rise = cyc;
            tgl = ~tgl;
        end
        prev_pc = pdm_clk;
        if (l_valid) begin
            lv_cnt++;
            rise_at_lv_prev = rise_at_lv;
            rise_at_lv = rise_cnt;
        end
        if (r_valid) rv_cnt++;
        case (mode)
            0: pdm_din = 1'b0;
            1: pdm_din = 1'b1;
            2: pdm_din = ~pdm_clk;
            3: pdm_din = pdm_clk;
            default: pdm_din = tgl;
        endcase
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_l(input int n);
        int target;
        target = lv_cnt + n;
        while (lv_cnt < target) step(1);
    endtask

    task automatic wait_r(input int n);
        int target;
        target = rv_cnt + n;
        while (rv_cnt < target) step(1);
    endtask

    task automatic wait_rise(input int n);
        int target;
        target = rise_cnt + n;
        while (rise_cnt < target) step(1);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, v, n;
        step(5);
        // R11: reset state
        check(l_pcm == 0 && r_pcm == 0, "R11 pcm", int'(l_pcm), 0);
        check(!l_valid && !r_valid && !pdm_clk, "R11 strobes/clock", int'({l_valid, r_valid, pdm_clk}), 0);
        rst_n = 1;

        // R10: clock idle with no channel running, then with clk_en low
        step(40);
        check(rise_cnt == 0 && !pdm_clk, "R10 no channel", rise_cnt, 0);
        clk_en = 0;
        l_en = 1;
        step(40);
        check(rise_cnt == 0 && !pdm_clk, "R10 clk_en low", rise_cnt, 0);

        // R9: start-up drop of four outputs, left only
        mode = 1;
        base = rise_cnt;
        clk_en = 1;
        wait_l(1);
        check(rise_at_lv - base == 320, "R9 first strobe", rise_at_lv - base, 320);
        check(rv_cnt == 0 && r_pcm == 0, "R8 right disabled", rv_cnt, 0);
        wait_l(1);
        check(rise_at_lv - rise_at_lv_prev == 64, "R2 spacing", rise_at_lv - rise_at_lv_prev, 64);
        check($signed(l_pcm) == 32767, "R4 ones", $signed(l_pcm), 32767);

        // Vector table: pattern and gains against both channels
        r_en = 1;
        for (int i = 0; i < NV; i++) begin
            mode = V_MODE[i];
            l_gain = 14'(V_LG[i]);
            r_gain = 14'(V_RG[i]);
            wait_l(6);
            wait_r(1);
            check($signed(l_pcm) == V_LE[i], {V_TAG[i], " left"}, $signed(l_pcm), V_LE[i]);
            check($signed(r_pcm) == V_RE[i], {V_TAG[i], " right"}, $signed(r_pcm), V_RE[i]);
        end

        // R3: clock period per rate code
        for (int c = 0; c < 4; c++) begin
            int expp;
            rate_sel = 2'(c);
            expp = (c == 0) ? 2 * H0 : (c == 3) ? 2 * H3 : 2 * H1;
            wait_rise(3);
            check(last_rise - prev_rise == expp, "R3 period", last_rise - prev_rise, expp);
        end
        rate_sel = 2'd1;

        // R8: pause left while right keeps the clock running
        mode = 1;
        l_gain = 14'h400;
        r_gain = 14'h400;
        wait_l(6);
        l_en = 0;
        step(1);
        v = int'(l_pcm);
        n = lv_cnt;
        step(600);
        check(lv_cnt == n, "R8 no strobe", lv_cnt - n, 0);
        check(int'(l_pcm) == v, "R8 hold", int'(l_pcm), v);
        l_en = 1;
        wait_l(2);
        check($signed(l_pcm) == 32767, "R8 resume", $signed(l_pcm), 32767);

        // R7: soft reset clears output and restarts the drop count
        l_srst_n = 0;
        n = lv_cnt;
        step(300);
        check(lv_cnt == n && l_pcm == 0, "R7 held", int'(l_pcm), 0);
        base = rise_cnt;
        l_srst_n = 1;
        wait_l(1);
        check(rise_at_lv - base == 320, "R7 R9 restart", rise_at_lv - base, 320);
        check($signed(l_pcm) == 32767, "R7 value", $signed(l_pcm), 32767);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule